// File: doc/BRIEF.md
# Transaction Packet Transmit Packer

This block accepts a transaction-layer packet as a stream of 32-bit dwords and packs it into 128-bit beats for a streaming transmit bus. The packet arrives in order: first its 3- or 4-dword header, then its payload. Each dword arrives with a valid/ready handshake and an error bit.

The block reads the header as it arrives. From the header it learns the header size, whether there is a payload, the payload length and the quadword alignment of the address. From these it chooses the lane that holds the first payload dword. That can leave one lane of a beat unused, and the block drives that lane as zero. Each beat carries start-of-packet, end-of-packet, a flag that only the low half of the final beat is occupied, and an error flag. When the downstream side stalls, the current beat is held and the input is not accepted.

Top module: `tlp_tx_packer`

## Requirements
- R1: Lane k of a beat is out_data[32k+31:32k]. A 4-dword header fills the whole first beat, with H0 in lane 0 through H3 in lane 3.
- R2: A 3-dword header whose address dword (H2) has bit 2 set puts H0..H2 in lanes 0..2 and payload dword 0 in lane 3 of the same beat.
- R3: A 3-dword header whose H2 bit 2 is clear leaves lane 3 of the first beat at zero. Payload dword 0 goes in lane 0 of the next beat.
- R4: A 4-dword header whose address dword (H3) has bit 2 clear puts payload dword 0 in lane 0 of the second beat.
- R5: A 4-dword header whose H3 bit 2 is set leaves lane 0 of the second beat at zero. Payload dword 0 goes in lane 1.
- R6: Once placed, the payload dwords fill the following lanes in order, four per beat. Every lane not holding a header or payload dword reads zero.
- R7: H0 bit 29 selects a 4-dword header and H0 bit 30 marks a payload. H0[LEN_W-1:0] gives the payload dword count, where the value 0 means 2**LEN_W.
- R8: out_sop is high only on the first beat of a packet and out_eop only on its last beat. A packet without payload ends on its header beat. No beat is valid after reset.
- R9: On the end-of-packet beat, out_empty is high exactly when the last occupied lane is 0 or 1, and the upper 64 bits are then zero. It is low on every other beat.
- R10: While out_valid is high and out_ready low, out_data and all framing outputs stay unchanged and out_valid stays high.
- R11: in_ready is low whenever out_valid is high and out_ready low, so no dword is consumed until the held beat is taken.
- R12: out_err is high on a packet's end-of-packet beat when any of its dwords arrived with in_err set. It is low on all other beats and does not carry over to the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input dword valid |
| in_ready | output | 1 | Block can accept an input dword |
| in_data | input | 32 | Header or payload dword |
| in_err | input | 1 | Error marker for this dword |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 128 | Packed beat, lane 0 in the low bits |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_empty | output | 1 | Final beat uses only the low 64 bits |
| out_err | output | 1 | Packet carried an error |

## Verification
The bench builds the block with LEN_W = 4. A zero length field then means 16 payload dwords, so the wrap-around length case is reached in a few beats and not after 1024 dwords. Every payload length from 1 to 9 is run with all four header-size and alignment combinations, which puts the final dword in each of the four lanes. The bench also holds the output ready low in windows and at random, which tests the beat-hold behaviour against a queue model of the expected beats.

// File: rtl/tlp_tx_packer.sv
module tlp_tx_packer #(
  parameter int LEN_W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  in_data,
  input  logic         in_err,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data,
  output logic         out_sop,
  output logic         out_eop,
  output logic         out_empty,
  output logic         out_err
);
  localparam int CNT_W = LEN_W + 1;

  logic [3:0][31:0] lanes, nlanes;
  logic             ov, bsop, beop, bempty, berr;
  logic             in_hdr, is4, hasd, errp;
  logic [1:0]       hidx, lane;
  logic [CNT_W-1:0] rem;

  assign in_ready = !ov || out_ready;
  wire fire = in_valid && in_ready;

  wire             h0       = in_hdr && hidx == 2'd0;
  wire             cur_is4  = h0 ? in_data[29] : is4;
  wire             cur_hasd = h0 ? in_data[30] : hasd;
  wire [LEN_W-1:0] lf       = in_data[LEN_W-1:0];
  wire [CNT_W-1:0] cur_len  = (lf == '0) ? (CNT_W'(1) << LEN_W) : {1'b0, lf};
  wire             last_hdr = in_hdr && hidx == (cur_is4 ? 2'd3 : 2'd2);
  wire             unal     = in_data[2];
  wire [1:0]       wl       = in_hdr ? hidx : lane;
  wire             data_end = !in_hdr && rem == CNT_W'(1);
  wire             eop_now  = (last_hdr && !cur_hasd) || data_end;
  wire             close    = eop_now || (!in_hdr && lane == 2'd3) ||
                              (last_hdr && (cur_is4 || !unal));

  always_comb begin
    nlanes     = ov ? '0 : lanes;
    nlanes[wl] = in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov     <= 1'b0;
      lanes  <= '0;
      bsop   <= 1'b0;
      beop   <= 1'b0;
      bempty <= 1'b0;
      berr   <= 1'b0;
      in_hdr <= 1'b1;
      hidx   <= 2'd0;
      lane   <= 2'd0;
      is4    <= 1'b0;
      hasd   <= 1'b0;
      errp   <= 1'b0;
      rem    <= '0;
    end else begin
      if (ov && out_ready) begin
        ov     <= 1'b0;
        lanes  <= '0;
        bsop   <= 1'b0;
        beop   <= 1'b0;
        bempty <= 1'b0;
        berr   <= 1'b0;
      end
      if (fire) begin
        lanes  <= nlanes;
        bsop   <= (!ov && bsop) || h0;
        beop   <= eop_now;
        bempty <= eop_now && !wl[1];
        berr   <= eop_now && (errp || in_err);
        errp   <= eop_now ? 1'b0 : (errp || in_err);
        if (close) ov <= 1'b1;
        if (h0) begin
          is4  <= in_data[29];
          hasd <= in_data[30];
          rem  <= cur_len;
        end
        if (in_hdr) begin
          if (last_hdr) begin
            hidx <= 2'd0;
            if (cur_hasd) begin
              in_hdr <= 1'b0;
              lane   <= cur_is4 ? {1'b0, unal} : (unal ? 2'd3 : 2'd0);
            end
          end else begin
            hidx <= hidx + 2'd1;
          end
        end else begin
          rem  <= rem - CNT_W'(1);
          lane <= lane + 2'd1;
          if (data_end) begin
            in_hdr <= 1'b1;
            hidx   <= 2'd0;
          end
        end
      end
    end
  end

  assign out_valid = ov;
  assign out_data  = lanes;
  assign out_sop   = bsop;
  assign out_eop   = beop;
  assign out_empty = bempty;
  assign out_err   = berr;
endmodule

// File: rtl/tlp_tx_packer_chk.sv
module tlp_tx_packer_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_data,
  input logic         out_sop,
  input logic         out_eop,
  input logic         out_empty,
  input logic         out_err
);
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
  AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable({out_sop, out_eop, out_empty, out_err})); // R10
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R11
  AST_EMPTY_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_empty |-> out_eop && out_data[127:64] == '0); // R9
  AST_ERR_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_eop); // R12
endmodule

bind tlp_tx_packer tlp_tx_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
  .out_eop(out_eop), .out_empty(out_empty), .out_err(out_err)
);

// File: tb/tb_tlp_tx_packer.sv
module tb_tlp_tx_packer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_err = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop, out_empty, out_err;
  logic [127:0] out_data;

  always #2.5 clk = ~clk;

  tlp_tx_packer #(.LEN_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_err(in_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_empty(out_empty), .out_err(out_err)
  );

  int checks = 0, errors = 0, uid = 0;
  logic [31:0]  sd[$];
  bit           se[$];
  logic [127:0] ed[$];
  logic [3:0]   ef[$];
  string        et[$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_pkt(input bit is4, input bit hasd, input int lenf, input bit unal,
                         input int errpos, input string tag);
    logic [31:0] sv[$];
    bit sr[$];
    int n, hc, k, nb;
    bit anyerr;
    logic [31:0] v;
    logic [127:0] bd;
    bit lastlo;
    n = hasd ? ((lenf == 0) ? 16 : lenf) : 0;
    hc = is4 ? 4 : 3;
    k = 0;
    anyerr = 0;
    uid++;
    for (int i = 0; i < hc; i++) begin
      if (i == 0) v = {1'b0, hasd, is4, 25'd0, 4'(lenf)};
      else begin
        v = 32'hA500_0000 | (32'(uid) << 8) | (32'(i) << 4) | 32'h1;
        if (i == hc - 1) v[2] = unal;
      end
      sd.push_back(v); se.push_back(k == errpos); anyerr |= (k == errpos); k++;
      sv.push_back(v); sr.push_back(1'b1);
    end
    if (hasd && (is4 == unal)) begin sv.push_back('0); sr.push_back(1'b0); end
    for (int j = 0; j < n; j++) begin
      v = 32'hD000_0000 | (32'(uid) << 12) | 32'(j + 1);
      sd.push_back(v); se.push_back(k == errpos); anyerr |= (k == errpos); k++;
      sv.push_back(v); sr.push_back(1'b1);
    end
    while (sv.size() % 4 != 0) begin sv.push_back('0); sr.push_back(1'b0); end
    nb = sv.size() / 4;
    for (int b = 0; b < nb; b++) begin
      for (int l = 0; l < 4; l++) bd[32*l +: 32] = sv[4*b + l];
      lastlo = (b == nb - 1) && !sr[4*b + 2] && !sr[4*b + 3];
      ed.push_back(bd);
      ef.push_back({b == 0, b == nb - 1, lastlo, (b == nb - 1) && anyerr});
      et.push_back(tag);
    end
  endtask

  initial begin
    int cyc;
    bit prev_stall;
    logic [127:0] pd;
    logic [3:0] pf, ex;
    prev_stall = 0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R8 reset no beat", 128'(out_valid), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R11 idle after reset", {in_ready, out_valid}, 128'b10);

    add_pkt(1, 0, 0, 0, -1, "R1");
    add_pkt(0, 1, 1, 1, -1, "R2");
    add_pkt(0, 1, 6, 1, -1, "R2");
    add_pkt(0, 1, 4, 0, -1, "R3");
    add_pkt(1, 1, 5, 0, -1, "R4");
    add_pkt(1, 1, 3, 1, -1, "R5");
    add_pkt(0, 0, 0, 1, -1, "R8");
    add_pkt(0, 1, 0, 0, -1, "R7");
    add_pkt(1, 1, 0, 1, -1, "R7");
    add_pkt(1, 1, 4, 1, 5, "R12");
    add_pkt(0, 1, 2, 1, -1, "R12");
    add_pkt(0, 1, 1, 0, 1, "R12");
    for (int l = 1; l <= 9; l++)
      for (int c = 0; c < 4; c++)
        add_pkt(c[1], 1, l, c[0], -1, "R6");

    cyc = 0;
    while ((sd.size() > 0 || ed.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (prev_stall) begin
        chk(out_valid && out_data == pd, "R10 held data", out_data, pd);
        chk({out_sop, out_eop, out_empty, out_err} == pf, "R10 held framing",
            {out_sop, out_eop, out_empty, out_err}, pf);
      end
      out_ready = ((cyc % 60) < 8) ? 1'b0 : ($urandom % 4 != 0);
      in_valid  = (sd.size() > 0) && ($urandom % 5 != 0);
      in_data   = (sd.size() > 0) ? sd[0] : '0;
      in_err    = (sd.size() > 0) ? se[0] : 1'b0;
      #1;
      if (out_valid && !out_ready) chk(!in_ready, "R11 input blocked", 128'(in_ready), 128'd0);
      if (out_valid && out_ready) begin
        if (ed.size() == 0) chk(1'b0, "R6 unexpected beat", out_data, '0);
        else begin
          ex = ef.pop_front();
          chk(out_data == ed[0], et[0], out_data, ed[0]);
          chk({out_sop, out_eop} == ex[3:2], "R8 framing", {out_sop, out_eop}, ex[3:2]);
          chk(out_empty == ex[1], "R9 empty", 128'(out_empty), 128'(ex[1]));
          chk(out_err == ex[0], "R12 error flag", 128'(out_err), 128'(ex[0]));
          void'(ed.pop_front());
          void'(et.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        void'(sd.pop_front());
        void'(se.pop_front());
      end
      prev_stall = out_valid && !out_ready;
      pd = out_data;
      pf = {out_sop, out_eop, out_empty, out_err};
    end
    if (cyc >= 20000) chk(1'b0, "R6 watchdog expired", 128'(ed.size()), 128'd0);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid && ed.size() == 0, "R6 all beats delivered", 128'(out_valid), 128'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule